// File: doc/BRIEF.md
# Acquisition Select and Gain Register

This block holds the setup word for a multiplexed analog front end. A host writes a 16-bit word that carries a gain code, an acquisition mode and a five-bit channel index, and reads back that word together with two status flags supplied by the conversion sequencer. The block turns the stored fields into a two-bit amplifier gain code and a registered one-hot select vector that drives the analog multiplexers.

The select vector has one line per analog source. Lines 0 to 19 are the differential pairs, lines 20 to 23 the four calibration sources, lines 24 to 63 the single-ended inputs 0 to 39, and line 64 the auto-zero input. The block decodes the fields only. It does not judge whether a selection makes sense for the wiring: a combination that has no source simply drives no line.

Top module: `acq_ctrl_reg`

## Requirements
- R1: While reset is held and after it is released, every stored bit is zero. A read returns 0x0000 when both status inputs are low, `gain_code` is 00, and `sel_line` has only line 0 (differential pair 0) high.
- R2: Bits 13:0 read back exactly as last written. This includes the spare bits 5 and 13:10, which have no other effect.
- R3: Read bit 15 equals `conv_trig_i` and read bit 14 equals `data_rdy_i` at the time of the read. Values written to bits 15:14 are ignored.
- R4: `gain_code` equals stored bits 7:6 (00 means x1, 01 x2, 10 x4, 11 x8) from the clock edge that takes the write.
- R5: With mode bits 9:8 = 00 and index {bit4, bits3:0} from 0 to 19, only line `index` (differential pair) is high.
- R6: With mode 00 and index 20 to 23, only line `index` is high, so calibration source k = index-20 is on line 20+k.
- R7: With mode 10 and index 0 to 19, only line 44+index is high (single-ended input 20+index).
- R8: With mode 01 and index 0 to 19, only line 24+index is high (single-ended input index).
- R9: With mode 11, only line 64 (auto-zero) is high, whatever the other bits hold.
- R10: At most one select line is ever high. An index above 23 in mode 00, or above 19 in modes 01 and 10, leaves every line low.
- R11: `sel_line` changes on the clock edge after the edge that takes a write, and it holds its value when no write has occurred.
- R12: While `rd_en` is low, `rdata` is 0x0000.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Write strobe, one cycle per write |
| rd_en | input | 1 | Read strobe, enables `rdata` |
| wdata | input | 16 | Write data |
| rdata | output | 16 | Read data: status flags in bits 15:14, stored bits in 13:0 |
| conv_trig_i | input | 1 | Conversion-triggered flag from the sequencer |
| data_rdy_i | input | 1 | Data-ready flag from the sequencer |
| gain_code | output | 2 | Amplifier gain code |
| sel_line | output | 65 | Registered one-hot multiplexer select |

## Verification
A stored field that goes wrong becomes visible on the next read and in `gain_code` right away. A corrupted mode or index shows up on `sel_line` one clock after the write edge, either as the wrong line, as two lines high, or as no line high. The bench walks every mode against every index value, so a misplaced offset between the differential, calibration, single-ended and auto-zero groups shows up as a wrong line within two cycles of the write that set it. A write that leaks into the status bits, or a select that moves without a write, shows up on the first read or on the first idle cycle after it.

// File: rtl/acq_ctrl_pkg.sv
package acq_ctrl_pkg;
   localparam int WORD_W  = 16;
   localparam int IDX_W   = 5;
   localparam int GAIN_W  = 2;
   localparam int STORE_W = 14;

   typedef enum logic [1:0] {
      MODE_DIFF  = 2'b00,
      MODE_SE_LO = 2'b01,
      MODE_SE_HI = 2'b10,
      MODE_AZERO = 2'b11
   } acq_mode_e;

   typedef struct packed {
      logic [3:0]        spare_hi;
      acq_mode_e         mode;
      logic [GAIN_W-1:0] gain;
      logic              spare_lo;
      logic [IDX_W-1:0]  idx;
   } acq_ctrl_t;
endpackage

// File: rtl/acq_ctrl_store.sv
module acq_ctrl_store
   import acq_ctrl_pkg::*;
(
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic              rd_en,
   input  logic [WORD_W-1:0] wdata,
   input  logic              conv_trig_i,
   input  logic              data_rdy_i,
   output logic [WORD_W-1:0] rdata,
   output acq_ctrl_t         ctrl
);
   acq_ctrl_t store_q;

   always_ff @(posedge clk) begin
      if (!rst_n)     store_q <= '0;
      else if (wr_en) store_q <= acq_ctrl_t'(wdata[STORE_W-1:0]);
   end

   assign ctrl  = store_q;
   assign rdata = rd_en ? {conv_trig_i, data_rdy_i, store_q} : '0;
endmodule

// File: rtl/acq_sel_decode.sv
module acq_sel_decode
   import acq_ctrl_pkg::*;
#(
   parameter int N_PAIR = 20,
   parameter int N_CAL  = 4,
   localparam int N_SE    = 2 * N_PAIR,
   localparam int SE_BASE = N_PAIR + N_CAL,
   localparam int AZ_LINE = SE_BASE + N_SE,
   localparam int NSEL    = AZ_LINE + 1
)(
   input  acq_mode_e        mode,
   input  logic [IDX_W-1:0] idx,
   output logic [NSEL-1:0]  sel
);
   if (N_PAIR + N_CAL > (1 << IDX_W)) begin : g_bad_diff
      $error("acq_sel_decode: pairs plus calibration exceed index range");
   end
   if (N_PAIR < 1 || N_CAL < 0) begin : g_bad_cnt
      $error("acq_sel_decode: bad source counts");
   end

   for (genvar l = 0; l < NSEL; l++) begin : g_line
      if (l < SE_BASE) begin : g_diff_cal
         assign sel[l] = (mode == MODE_DIFF) && (idx == IDX_W'(l));
      end else if (l < SE_BASE + N_PAIR) begin : g_se_lo
         assign sel[l] = (mode == MODE_SE_LO) && (idx == IDX_W'(l - SE_BASE));
      end else if (l < AZ_LINE) begin : g_se_hi
         assign sel[l] = (mode == MODE_SE_HI) && (idx == IDX_W'(l - SE_BASE - N_PAIR));
      end else begin : g_azero
         assign sel[l] = (mode == MODE_AZERO);
      end
   end
endmodule

// File: rtl/acq_ctrl_reg.sv
module acq_ctrl_reg
   import acq_ctrl_pkg::*;
#(
   parameter int N_PAIR = 20,
   parameter int N_CAL  = 4,
   localparam int NSEL  = N_PAIR + N_CAL + 2 * N_PAIR + 1
)(
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic              rd_en,
   input  logic [WORD_W-1:0] wdata,
   output logic [WORD_W-1:0] rdata,
   input  logic              conv_trig_i,
   input  logic              data_rdy_i,
   output logic [GAIN_W-1:0] gain_code,
   output logic [NSEL-1:0]   sel_line
);
   localparam logic [NSEL-1:0] SEL_RST = NSEL'(1);

   acq_ctrl_t       ctrl;
   logic [NSEL-1:0] sel_next;

   acq_ctrl_store i_store (
      .clk         (clk),
      .rst_n       (rst_n),
      .wr_en       (wr_en),
      .rd_en       (rd_en),
      .wdata       (wdata),
      .conv_trig_i (conv_trig_i),
      .data_rdy_i  (data_rdy_i),
      .rdata       (rdata),
      .ctrl        (ctrl)
   );

   acq_sel_decode #(.N_PAIR(N_PAIR), .N_CAL(N_CAL)) i_decode (
      .mode (ctrl.mode),
      .idx  (ctrl.idx),
      .sel  (sel_next)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) sel_line <= SEL_RST;
      else        sel_line <= sel_next;
   end

   assign gain_code = ctrl.gain;
endmodule

// File: rtl/acq_ctrl_chk.sv
module acq_ctrl_chk #(
   parameter int N_PAIR = 20,
   parameter int N_CAL  = 4,
   localparam int NSEL  = N_PAIR + N_CAL + 2 * N_PAIR + 1
)(
   input logic            clk,
   input logic            rst_n,
   input logic            wr_en,
   input logic            rd_en,
   input logic [15:0]     wdata,
   input logic [15:0]     rdata,
   input logic            conv_trig_i,
   input logic            data_rdy_i,
   input logic [1:0]      gain_code,
   input logic [NSEL-1:0] sel_line
);
   a_r10_onehot0: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(sel_line));

   a_r4_gain_follows_write: assert property (@(posedge clk) disable iff (!rst_n)
      $past(wr_en) |-> gain_code == $past(wdata[7:6]));

   a_r2_readback: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(wr_en) && rd_en) |-> rdata[13:0] == $past(wdata[13:0]));

   a_r3_status_bits: assert property (@(posedge clk) disable iff (!rst_n)
      rd_en |-> rdata[15:14] == {conv_trig_i, data_rdy_i});

   a_r12_idle_read: assert property (@(posedge clk) disable iff (!rst_n)
      !rd_en |-> rdata == 16'h0000);

   a_r11_sel_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (!$past(wr_en) && !$past(wr_en, 2)) |-> $stable(sel_line));

   a_r9_autozero: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(wr_en, 2) && $past(wdata[9:8], 2) == 2'b11 && !$past(wr_en))
      |-> sel_line[NSEL-1]);
endmodule

bind acq_ctrl_reg acq_ctrl_chk #(.N_PAIR(N_PAIR), .N_CAL(N_CAL)) i_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .wr_en       (wr_en),
   .rd_en       (rd_en),
   .wdata       (wdata),
   .rdata       (rdata),
   .conv_trig_i (conv_trig_i),
   .data_rdy_i  (data_rdy_i),
   .gain_code   (gain_code),
   .sel_line    (sel_line)
);

// File: tb/test_acq_ctrl_reg.sv
module test_acq_ctrl_reg;
   localparam int CLK_P = 10;
   localparam int NSEL  = 65;

   logic            clk = 1'b0;
   logic            rst_n = 1'b0;
   logic            wr_en = 1'b0;
   logic            rd_en = 1'b0;
   logic [15:0]     wdata = '0;
   logic [15:0]     rdata;
   logic            conv_trig_i = 1'b0;
   logic            data_rdy_i = 1'b0;
   logic [1:0]      gain_code;
   logic [NSEL-1:0] sel_line;

   int checks = 0;
   int errors = 0;

   always #(CLK_P/2) clk = ~clk;

   acq_ctrl_reg i_acq_ctrl_reg (
      .clk         (clk),
      .rst_n       (rst_n),
      .wr_en       (wr_en),
      .rd_en       (rd_en),
      .wdata       (wdata),
      .rdata       (rdata),
      .conv_trig_i (conv_trig_i),
      .data_rdy_i  (data_rdy_i),
      .gain_code   (gain_code),
      .sel_line    (sel_line)
   );

   function automatic int exp_line(int m, int i);
      case (m)
         0: return (i < 24) ? i : -1;
         1: return (i < 20) ? 24 + i : -1;
         2: return (i < 20) ? 44 + i : -1;
         default: return 64;
      endcase
   endfunction

   function automatic logic [NSEL-1:0] line_vec(int l);
      logic [NSEL-1:0] v = '0;
      if (l >= 0) v[l] = 1'b1;
      return v;
   endfunction

   task automatic check16(string req, logic [15:0] act, logic [15:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic check_sel(string req, logic [NSEL-1:0] exp);
      checks++;
      if (sel_line !== exp) begin
         errors++;
         $display("FAIL %s actual=%h expected=%h", req, sel_line, exp);
      end
   endtask

   // write lands at the next posedge; returns at the negedge after it
   task automatic do_write(logic [15:0] v);
      @(negedge clk);
      wdata = v;
      wr_en = 1'b1;
      @(negedge clk);
      wr_en = 1'b0;
      wdata = '0;
   endtask

   task automatic do_read(output logic [15:0] v);
      rd_en = 1'b1;
      #1;
      v = rdata;
      rd_en = 1'b0;
      #1;
   endtask

   task automatic t_reset;
      logic [15:0] v;
      check_sel("R1 sel during reset", line_vec(0));
      @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      do_read(v);
      check16("R1 read after reset", v, 16'h0000);
      check16("R1 gain after reset", {14'd0, gain_code}, 16'h0000);
      check_sel("R1 sel after reset", line_vec(0));
   endtask

   task automatic t_readback;
      logic [15:0] v;
      do_write(16'h3C25);
      do_read(v);
      check16("R2 readback spare bits", v, 16'h3C25);
      do_write(16'h03DA);
      do_read(v);
      check16("R2 readback second pattern", v, 16'h03DA);
   endtask

   task automatic t_status;
      logic [15:0] v;
      do_write(16'hC000);
      do_read(v);
      check16("R3 status ignores write", v, 16'h0000);
      conv_trig_i = 1'b1;
      do_read(v);
      check16("R3 trig flag in bit15", v, 16'h8000);
      data_rdy_i = 1'b1;
      conv_trig_i = 1'b0;
      do_read(v);
      check16("R3 ready flag in bit14", v, 16'h4000);
      data_rdy_i = 1'b0;
   endtask

   task automatic t_idle_read;
      do_write(16'h1234);
      #1;
      check16("R12 rdata zero without rd_en", rdata, 16'h0000);
   endtask

   task automatic t_timing;
      do_write(16'h0014);
      @(negedge clk);
      do_write(16'h00C5);
      check16("R4 gain at write edge", {14'd0, gain_code}, 16'h0003);
      check_sel("R11 sel still old after write edge", line_vec(20));
      @(negedge clk);
      check_sel("R11 sel new one edge later", line_vec(5));
      repeat (3) @(negedge clk);
      check_sel("R11 sel holds without write", line_vec(5));
   endtask

   task automatic t_examples;
      do_write(16'h02D3);
      @(negedge clk);
      check_sel("R7 word 02D3 single-ended 39", line_vec(63));
      check16("R4 gain x8", {14'd0, gain_code}, 16'h0003);
      do_write(16'h00D7);
      @(negedge clk);
      check_sel("R6 word 00D7 cal source 3", line_vec(23));
      do_write(16'h0300);
      @(negedge clk);
      check_sel("R9 word 0300 auto-zero", line_vec(64));
   endtask

   task automatic t_sweep;
      for (int m = 0; m < 4; m++) begin
         for (int i = 0; i < 32; i++) begin
            logic [15:0] w;
            w = {2'b11, 4'(i), 2'(m), 2'(i), 1'(i), 5'(i)};
            do_write(w);
            @(negedge clk);
            case (m)
               0: check_sel(i < 20 ? "R5 diff sweep" : (i < 24 ? "R6 cal sweep" : "R10 mode00 out of range"),
                            line_vec(exp_line(m, i)));
               1: check_sel(i < 20 ? "R8 se-lo sweep" : "R10 mode01 out of range", line_vec(exp_line(m, i)));
               2: check_sel(i < 20 ? "R7 se-hi sweep" : "R10 mode10 out of range", line_vec(exp_line(m, i)));
               default: check_sel("R9 auto-zero sweep", line_vec(exp_line(m, i)));
            endcase
            check16("R4 gain sweep", {14'd0, gain_code}, 16'(i & 3));
         end
      end
   endtask

   initial begin
      repeat (3) @(negedge clk);
      t_reset();
      t_readback();
      t_status();
      t_idle_read();
      t_timing();
      t_examples();
      t_sweep();
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      #(CLK_P * 100000);
      checks++;
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule